// File: doc/BRIEF.md
# Chip-Select Gated Registered Fanout Buffer

This block is the input register stage of a memory-module address and command buffer. Each clock it captures a 28-bit data word and drives every captured bit onto two separate output copies, so that one stage can feed two stacked groups of memory loads. Two active-low chip-select inputs are registered as well, and their registered copies are always passed through.

A gate-enable input lets the chip selects suppress switching. While gate-enable is high and both chip selects are deasserted, the data outputs keep their previous value, which saves power on the wide output bus. While gate-enable is low, the data outputs follow the input on every edge whatever the chip selects are. An active-low reset clears every register and forces every output low at once. Its release is synchronised to the clock.

Top module: `csgate_fanout_reg`

## Requirements
- R1: While out of reset, when gate-enable is low or at least one chip select is low at a rising clock edge, both data output copies take the value of `d` sampled at that edge.
- R2: The outputs `q_a` and `q_b` always carry identical values.
- R3: While `rst_n` is low, `q_a`, `q_b` and `qcs_n` are all zero. The clearing takes effect without waiting for a clock edge.
- R4: When gate-enable is high and both chip-select inputs are high at a rising edge, the data outputs keep their value across that edge.
- R5: When gate-enable is low, the chip-select inputs have no effect on data capture. The data outputs update even when both chip selects are high.
- R6: While out of reset, `qcs_n` takes the value of `cs_n` sampled at every rising edge, whether or not the data outputs are gated.
- R7: After `rst_n` rises, the first two rising edges leave all outputs at zero. The third rising edge is the first one that captures inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; inputs are captured on its rising edge |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| gate_en | input | 1 | High: chip selects may freeze the data outputs |
| cs_n | input | NCS (2) | Active-low chip selects, bit 0 and bit 1 |
| d | input | DW (28) | Data word to register |
| q_a | output | DW (28) | Registered data, first copy |
| q_b | output | DW (28) | Registered data, second copy |
| qcs_n | output | NCS (2) | Registered chip selects, never gated |

## Verification
Gating and reset release can fall in the same cycle. So can gating and chip-select pass-through. The bench holds both chip selects high with gate-enable high while reset is released, so the third edge after release must keep the cleared data and still pass the chip selects through. Random runs also flip gate-enable on the same edge where both chip selects go high. A behavioural reference model counts edges since release and decides, edge by edge, whether data updates or holds. The outputs are compared with the model between edges.

// File: rtl/csgate_fanout_reg.sv
module csgate_fanout_reg #(
  parameter int DW  = 28,
  parameter int NCS = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           gate_en,
  input  logic [NCS-1:0] cs_n,
  input  logic [DW-1:0]  d,
  output logic [DW-1:0]  q_a,
  output logic [DW-1:0]  q_b,
  output logic [NCS-1:0] qcs_n
);

  logic [1:0] rsync;
  logic       run;
  logic       hold;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rsync <= '0;
    else        rsync <= {rsync[0], 1'b1};

  assign run  = rsync[1];
  assign hold = gate_en & (&cs_n);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     q_a <= '0;
    else if (!run)  q_a <= '0;
    else if (!hold) q_a <= d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     q_b <= '0;
    else if (!run)  q_b <= '0;
    else if (!hold) q_b <= d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    qcs_n <= '0;
    else if (!run) qcs_n <= '0;
    else           qcs_n <= cs_n;

  AST_COPIES_MATCH: assert property (@(posedge clk) q_a == q_b); // R2
  AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> (q_a == '0 && q_b == '0 && qcs_n == '0)); // R3
  AST_OPEN_CAPTURES: assert property (@(posedge clk) disable iff (!run) !hold |=> q_a == $past(d)); // R1
  AST_GATED_HOLDS: assert property (@(posedge clk) disable iff (!run) hold |=> $stable(q_a)); // R4
  AST_GATE_OFF_IGNORES_CS: assert property (@(posedge clk) disable iff (!run) (!gate_en && (&cs_n)) |=> q_a == $past(d)); // R5
  AST_CS_PASSES: assert property (@(posedge clk) disable iff (!run) 1'b1 |=> qcs_n == $past(cs_n)); // R6
  AST_RELEASE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) $rose(rst_n) |=> (q_a == '0 && qcs_n == '0)); // R7

endmodule

// File: tb/csgate_fanout_reg_tb.sv
module csgate_fanout_reg_tb;
  localparam int DW  = 28;
  localparam int NCS = 2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           gate_en = 1'b0;
  logic [NCS-1:0] cs_n = '1;
  logic [DW-1:0]  d = '0;
  logic [DW-1:0]  q_a, q_b;
  logic [NCS-1:0] qcs_n;

  int checks = 0;
  int failures = 0;

  logic [DW-1:0]  m_q = '0;
  logic [NCS-1:0] m_cs = '0;
  int             edges_up = 0;
  string          last_tag = "R3";

  always #2 clk = ~clk;

  csgate_fanout_reg #(.DW(DW), .NCS(NCS)) u_dut (
    .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .cs_n(cs_n),
    .d(d), .q_a(q_a), .q_b(q_b), .qcs_n(qcs_n)
  );

  always @(negedge rst_n) begin
    m_q = '0; m_cs = '0; edges_up = 0; last_tag = "R3";
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_q = '0; m_cs = '0; edges_up = 0; last_tag = "R3";
    end else begin
      edges_up = edges_up + 1;
      if (edges_up < 3) begin
        m_q = '0; m_cs = '0; last_tag = "R7";
      end else begin
        m_cs = cs_n;
        if (gate_en && cs_n == '1) last_tag = "R4";
        else begin
          m_q = d;
          last_tag = (!gate_en && cs_n == '1) ? "R5" : "R1";
        end
      end
    end
  end

  task automatic check_all(string why);
    checks++;
    if (q_a !== m_q) begin
      failures++;
      $display("FAIL %s %s q_a=%h exp=%h", last_tag, why, q_a, m_q);
    end
    checks++;
    if (q_b !== q_a) begin
      failures++;
      $display("FAIL R2 %s q_b=%h exp=%h", why, q_b, q_a);
    end
    checks++;
    if (qcs_n !== m_cs) begin
      failures++;
      $display("FAIL %s %s qcs_n=%b exp=%b", (last_tag == "R3" || last_tag == "R7") ? last_tag : "R6", why, qcs_n, m_cs);
    end
  endtask

  task automatic step(input logic ge, input logic [NCS-1:0] cs, input logic [DW-1:0] dv);
    gate_en = ge; cs_n = cs; d = dv;
    @(negedge clk);
    check_all("step");
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_all("reset state R3");
    // R7: release with gating active; quiet edges then held data
    gate_en = 1'b1; cs_n = 2'b11; d = 28'h5A5A5A5;
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check_all("release R7");
    end
    // R1: capture with each chip select active
    step(1'b1, 2'b10, 28'h1234567);
    step(1'b1, 2'b01, 28'hFEDCBA9);
    step(1'b1, 2'b00, 28'hFFFFFFF);
    // R4: gated hold while data changes
    step(1'b1, 2'b11, 28'h0000001);
    step(1'b1, 2'b11, 28'h0ABCDEF);
    // R5: gate-enable low, chip selects idle, still captures
    step(1'b0, 2'b11, 28'h7777777);
    step(1'b0, 2'b11, 28'h0F0F0F0);
    step(1'b0, 2'b00, 28'h3333333);
    // R3: asynchronous clear mid-cycle
    #1 rst_n = 1'b0;
    #0.5;
    checks++;
    if (q_a !== '0 || q_b !== '0 || qcs_n !== '0) begin
      failures++;
      $display("FAIL R3 async clear q_a=%h q_b=%h qcs_n=%b exp=0", q_a, q_b, qcs_n);
    end
    @(negedge clk);
    check_all("reset held R3");
    @(negedge clk);
    rst_n = 1'b1;
    // random mix of gating, chip selects and occasional resets
    for (int n = 0; n < 3000; n++) begin
      logic ge;
      logic [NCS-1:0] cs;
      ge = 1'($urandom_range(0, 1));
      cs = ($urandom_range(0, 3) == 0) ? 2'(($urandom)) : 2'b11;
      if ($urandom_range(0, 199) == 0) rst_n = 1'b0;
      else if (!rst_n && $urandom_range(0, 2) == 0) rst_n = 1'b1;
      step(ge, cs, 28'($urandom));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule